// File: doc/BRIEF.md
# Descriptor-Chained Memory Copy Engine

This block is a single-channel copy engine. It moves 32-bit words from a source region to a destination region of a shared memory. The work list is a small on-chip table of descriptors. Each descriptor gives:

- a source byte address,
- a destination byte address,
- a byte count,
- a valid flag,
- a terminate flag.

Software fills the table and sets the start index in the pointer register. It then writes the start bit of the command register. From that point the engine runs with no further help and no per-word request lines.

For each valid descriptor the engine reads words from the source and writes them to the destination. When the descriptor is finished, the engine clears its valid flag and advances to the next table slot. The slot index wraps to zero after the highest slot. After the final descriptor of the chain, the engine pulses a completion output for one cycle.

The master port is a simple request/grant memory interface. Reads are issued as 4-beat bursts where possible. Writes are always single-beat. The pointer and the valid flags are altered during a run, so software rewrites them before the next start.

Top module: `chain_dma`

## Requirements
- R1: After reset, the status word reads 0, the pointer reads 0, every descriptor control word reads 0, and `bc` and `m_req` are low.
- R2: Writing 1 in bit 0 of register 0 while idle starts a run. `busy` (status bit 0) is high from the next cycle until the cycle after `bc`. `m_req` stays low whenever `busy` is low.
- R3: Every word is read from the source and then written to the destination. Addresses step by 4 bytes. The destination word k receives the source word k, and no word past the end is touched.
- R4: A read is a 4-beat burst (`m_burst`=1) while at least 4 words remain. A remainder of fewer than 4 words uses single reads. Every write is single-beat.
- R5: The byte count sits in bits 11:0 of the control word, and its low 2 bits are ignored. A count of 2048 or more copies exactly 512 words.
- R6: A valid descriptor with a word count of zero completes without any bus request and has its valid flag cleared.
- R7: A completed descriptor has its valid flag (control bit 31) cleared. The next slot, with index (i+1) mod the table depth, is fetched automatically.
- R8: A descriptor ends the chain when its terminate flag (control bit 30) is set, or when the next slot's valid flag is clear. A run that starts on an invalid slot ends with no bus requests and leaves the pointer unchanged.
- R9: `bc` pulses for exactly one cycle per run, after the final descriptor.
- R10: A start written while `busy` is high is ignored and sets the sticky error flag (status bit 1). Only reset clears that flag.
- R11: The pointer register is register 1. Writes to it while busy are ignored. After a run it holds the index of the slot following the last completed descriptor.
- R12: `m_req`, `m_we`, `m_burst`, `m_addr` and `m_wdata` hold steady while a request waits for `m_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Word address: 0 command/status, 1 pointer, 4+4*i+f descriptor i field f (0 src, 1 dst, 2 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| m_req | output | 1 | Master request |
| m_we | output | 1 | Request is a write |
| m_burst | output | 1 | Read request is a 4-beat burst |
| m_addr | output | 32 | Byte address |
| m_wdata | output | 32 | Write data |
| m_gnt | input | 1 | Request accepted this cycle |
| m_rvalid | input | 1 | Read data beat valid |
| m_rdata | input | 32 | Read data |
| busy | output | 1 | Run in progress |
| err | output | 1 | Sticky start-while-busy error |
| bc | output | 1 | Chain completion pulse |

## Verification
The hardest cases to reach from the ports are a start that lands while a run is active and a chain whose end is decided by the next slot's valid flag after the index wraps to zero.

For the first case, the stimulus issues a second start and a pointer write on the cycles right after the first start. It uses a long descriptor so the run is still busy at that time. The bench then checks that exactly one completion arrived and that the pointer follows the run.

For the wrap case, the chain starts two slots below the top of the table and holds a zero-length descriptor in slot 0. Slot 1 is left invalid. The bench then counts bursts, single reads and writes against the expected chunking.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned LEN_W      = 12;
    localparam int unsigned MAX_BYTES  = 2048;
    localparam int unsigned BURST_LEN  = 4;
    localparam int unsigned WORD_BYTES = DATA_W / 8;
    localparam int unsigned WSHIFT     = $clog2(WORD_BYTES);
    localparam int unsigned CNT_W      = $clog2(MAX_BYTES / WORD_BYTES) + 1;

    localparam int unsigned CTL_VALID_BIT = 31;
    localparam int unsigned CTL_LAST_BIT  = 30;

    localparam int unsigned REG_CMD   = 0;
    localparam int unsigned REG_PTR   = 1;
    localparam int unsigned DESC_BASE = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic              valid;
        logic              last;
        logic [LEN_W-1:0]  len;
    } desc_t;

    typedef enum logic [2:0] {
        CH_IDLE, CH_FETCH, CH_MOVE, CH_RETIRE, CH_DONE
    } chain_st_e;

    typedef enum logic [2:0] {
        MV_IDLE, MV_RREQ, MV_RDATA, MV_WREQ, MV_DONE
    } move_st_e;

    // Byte count to word count, saturated at the per-descriptor ceiling.
    function automatic logic [CNT_W-1:0] bytes_to_words(input logic [LEN_W-1:0] nbytes);
        if (nbytes >= LEN_W'(MAX_BYTES))
            return CNT_W'(MAX_BYTES / WORD_BYTES);
        return CNT_W'(nbytes >> WSHIFT);
    endfunction

endpackage

// File: rtl/cdma_desc_table.sv
module cdma_desc_table
    import cdma_pkg::*;
#(
    parameter int unsigned NDESC = 8,
    parameter int unsigned IW    = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [1:0]        wr_fld,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [IW-1:0]     clr_idx,
    input  logic [IW-1:0]     cur_idx,
    output desc_t             cur_desc,
    output logic [IW-1:0]     nxt_idx,
    output logic              nxt_valid,
    input  logic [IW-1:0]     sw_idx,
    input  logic [1:0]        sw_fld,
    output logic [DATA_W-1:0] sw_rdata
);

    desc_t ent [NDESC];

    logic unused_ctl;
    assign unused_ctl = ^wr_data[CTL_LAST_BIT-1:LEN_W];

    for (genvar g = 0; g < NDESC; g++) begin : g_ent
        desc_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else begin
                if (wr_en && wr_idx == IW'(g)) begin
                    case (wr_fld)
                        2'd0: q.src <= wr_data;
                        2'd1: q.dst <= wr_data;
                        2'd2: begin
                            q.valid <= wr_data[CTL_VALID_BIT];
                            q.last  <= wr_data[CTL_LAST_BIT];
                            q.len   <= wr_data[LEN_W-1:0];
                        end
                        default: ;
                    endcase
                end
                // Hardware retire has priority over a software write.
                if (clr_en && clr_idx == IW'(g))
                    q.valid <= 1'b0;
            end
        end
        assign ent[g] = q;
    end

    assign cur_desc  = ent[cur_idx];
    assign nxt_idx   = (cur_idx == IW'(NDESC - 1)) ? '0 : cur_idx + 1'b1;
    assign nxt_valid = ent[nxt_idx].valid;

    always_comb begin
        sw_rdata = '0;
        case (sw_fld)
            2'd0: sw_rdata = ent[sw_idx].src;
            2'd1: sw_rdata = ent[sw_idx].dst;
            2'd2: begin
                sw_rdata[CTL_VALID_BIT] = ent[sw_idx].valid;
                sw_rdata[CTL_LAST_BIT]  = ent[sw_idx].last;
                sw_rdata[LEN_W-1:0]     = ent[sw_idx].len;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cdma_mover.sv
module cdma_mover
    import cdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [LEN_W-1:0]  len,
    output logic              done,
    output logic              m_req,
    output logic              m_we,
    output logic              m_burst,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic              m_gnt,
    input  logic              m_rvalid,
    input  logic [DATA_W-1:0] m_rdata
);

    localparam int unsigned BW = $clog2(BURST_LEN);

    move_st_e          st;
    logic [ADDR_W-1:0] src_a, dst_a;
    logic [CNT_W-1:0]  rem;
    logic              is_burst;
    logic [BW-1:0]     beat;
    logic [DATA_W-1:0] dbuf [BURST_LEN];

    logic [BW-1:0]     last_beat;
    logic [CNT_W-1:0]  chunk;
    logic [CNT_W-1:0]  go_words;
    logic              can_burst;

    assign last_beat = is_burst ? BW'(BURST_LEN - 1) : '0;
    assign chunk     = is_burst ? CNT_W'(BURST_LEN) : CNT_W'(1);
    assign go_words  = bytes_to_words(len);
    assign can_burst = rem >= CNT_W'(BURST_LEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= MV_IDLE;
            src_a    <= '0;
            dst_a    <= '0;
            rem      <= '0;
            is_burst <= 1'b0;
            beat     <= '0;
        end else begin
            case (st)
                MV_IDLE: if (go) begin
                    src_a <= src;
                    dst_a <= dst;
                    rem   <= go_words;
                    beat  <= '0;
                    st    <= (go_words == '0) ? MV_DONE : MV_RREQ;
                end
                MV_RREQ: if (m_gnt) begin
                    is_burst <= can_burst;
                    beat     <= '0;
                    st       <= MV_RDATA;
                end
                MV_RDATA: if (m_rvalid) begin
                    if (beat == last_beat) begin
                        beat <= '0;
                        st   <= MV_WREQ;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                MV_WREQ: if (m_gnt) begin
                    dst_a <= dst_a + ADDR_W'(WORD_BYTES);
                    if (beat == last_beat) begin
                        src_a <= src_a + (ADDR_W'(chunk) << WSHIFT);
                        rem   <= rem - chunk;
                        beat  <= '0;
                        st    <= (rem == chunk) ? MV_DONE : MV_RREQ;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                MV_DONE: st <= MV_IDLE;
                default: st <= MV_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < BURST_LEN; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                dbuf[g] <= '0;
            else if (st == MV_RDATA && m_rvalid && beat == BW'(g))
                dbuf[g] <= m_rdata;
        end
    end

    assign m_req   = (st == MV_RREQ) || (st == MV_WREQ);
    assign m_we    = (st == MV_WREQ);
    assign m_burst = (st == MV_RREQ) && can_burst;
    assign m_addr  = (st == MV_WREQ) ? dst_a : src_a;
    assign m_wdata = dbuf[beat];
    assign done    = (st == MV_DONE);

    // R12: a pending request is held unchanged until it is granted.
    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        m_req && !m_gnt |=> m_req && $stable(m_we) && $stable(m_burst)
                            && $stable(m_addr) && $stable(m_wdata));

    // R6: a zero-word descriptor finishes next cycle with no request.
    a_r6_zero_len: assert property (@(posedge clk) disable iff (rst)
        go && st == MV_IDLE && bytes_to_words(len) == '0 |=> done && !m_req);

endmodule

// File: rtl/cdma_chain.sv
module cdma_chain
    import cdma_pkg::*;
#(
    parameter int unsigned NDESC = 8,
    parameter int unsigned IW    = $clog2(NDESC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_cmd,
    input  logic          ptr_we,
    input  logic [IW-1:0] ptr_wdata,
    input  logic          cur_valid,
    input  logic          cur_last,
    input  logic [IW-1:0] nxt_idx,
    input  logic          nxt_valid,
    input  logic          mv_done,
    output logic          mv_go,
    output logic          clr_en,
    output logic [IW-1:0] ptr_q,
    output logic          busy,
    output logic          err,
    output logic          bc
);

    chain_st_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= CH_IDLE;
            ptr_q <= '0;
            err   <= 1'b0;
        end else begin
            if (start_cmd && st != CH_IDLE)
                err <= 1'b1;
            case (st)
                CH_IDLE: begin
                    if (start_cmd)
                        st <= CH_FETCH;
                    else if (ptr_we)
                        ptr_q <= ptr_wdata;
                end
                CH_FETCH:  st <= cur_valid ? CH_MOVE : CH_DONE;
                CH_MOVE:   if (mv_done) st <= CH_RETIRE;
                CH_RETIRE: begin
                    ptr_q <= nxt_idx;
                    st    <= (cur_last || !nxt_valid) ? CH_DONE : CH_FETCH;
                end
                CH_DONE:   st <= CH_IDLE;
                default:   st <= CH_IDLE;
            endcase
        end
    end

    assign mv_go  = (st == CH_FETCH) && cur_valid;
    assign clr_en = (st == CH_RETIRE);
    assign busy   = (st != CH_IDLE);
    assign bc     = (st == CH_DONE);

    // R9: completion is a single pulse that ends the run.
    a_r9_bc_ends_run: assert property (@(posedge clk) disable iff (rst)
        bc |=> !bc && !busy);

    // R10: the error flag is sticky.
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R10: a start during a run raises the error flag.
    a_r10_start_busy: assert property (@(posedge clk) disable iff (rst)
        start_cmd && busy |=> err);

endmodule

// File: rtl/chain_dma.sv
module chain_dma
    import cdma_pkg::*;
#(
    parameter int unsigned NDESC = 8,
    parameter int unsigned RA_W  = $clog2(DESC_BASE + 4 * NDESC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              m_req,
    output logic              m_we,
    output logic              m_burst,
    output logic [31:0]       m_addr,
    output logic [31:0]       m_wdata,
    input  logic              m_gnt,
    input  logic              m_rvalid,
    input  logic [31:0]       m_rdata,
    output logic              busy,
    output logic              err,
    output logic              bc
);

    localparam int unsigned IW    = $clog2(NDESC);
    localparam int unsigned ROW_W = RA_W - 2;

    logic [ROW_W-1:0] row;
    logic [ROW_W-1:0] row_m1;
    logic             hit_desc;
    logic [IW-1:0]    desc_idx;
    logic [1:0]       fld;
    logic             start_cmd;
    logic             ptr_we;

    assign row      = reg_addr[RA_W-1:2];
    assign row_m1   = row - 1'b1;
    assign fld      = reg_addr[1:0];
    assign hit_desc = (row != '0) && (row_m1 < ROW_W'(NDESC)) && (fld != 2'd3);
    assign desc_idx = IW'(row_m1);
    assign start_cmd = reg_wr && reg_addr == RA_W'(REG_CMD) && reg_wdata[0];
    assign ptr_we    = reg_wr && reg_addr == RA_W'(REG_PTR);

    desc_t         cur_desc;
    logic [IW-1:0] nxt_idx;
    logic          nxt_valid;
    logic [31:0]   sw_rdata;
    logic          clr_en;
    logic [IW-1:0] ptr_q;
    logic          mv_go;
    logic          mv_done;

    cdma_desc_table #(.NDESC(NDESC)) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr && hit_desc),
        .wr_idx    (desc_idx),
        .wr_fld    (fld),
        .wr_data   (reg_wdata),
        .clr_en    (clr_en),
        .clr_idx   (ptr_q),
        .cur_idx   (ptr_q),
        .cur_desc  (cur_desc),
        .nxt_idx   (nxt_idx),
        .nxt_valid (nxt_valid),
        .sw_idx    (desc_idx),
        .sw_fld    (fld),
        .sw_rdata  (sw_rdata)
    );

    cdma_chain #(.NDESC(NDESC)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .start_cmd (start_cmd),
        .ptr_we    (ptr_we),
        .ptr_wdata (reg_wdata[IW-1:0]),
        .cur_valid (cur_desc.valid),
        .cur_last  (cur_desc.last),
        .nxt_idx   (nxt_idx),
        .nxt_valid (nxt_valid),
        .mv_done   (mv_done),
        .mv_go     (mv_go),
        .clr_en    (clr_en),
        .ptr_q     (ptr_q),
        .busy      (busy),
        .err       (err),
        .bc        (bc)
    );

    cdma_mover u_mover (
        .clk      (clk),
        .rst      (rst),
        .go       (mv_go),
        .src      (cur_desc.src),
        .dst      (cur_desc.dst),
        .len      (cur_desc.len),
        .done     (mv_done),
        .m_req    (m_req),
        .m_we     (m_we),
        .m_burst  (m_burst),
        .m_addr   (m_addr),
        .m_wdata  (m_wdata),
        .m_gnt    (m_gnt),
        .m_rvalid (m_rvalid),
        .m_rdata  (m_rdata)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == RA_W'(REG_CMD))
            reg_rdata = {30'd0, err, busy};
        else if (reg_addr == RA_W'(REG_PTR))
            reg_rdata = 32'(ptr_q);
        else if (hit_desc)
            reg_rdata = sw_rdata;
    end

    // R2: the master port is quiet whenever no run is active.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !m_req);

endmodule

// File: tb/sim_chain_dma.sv
module sim_chain_dma;

    localparam int RA_W = 6;
    localparam logic [31:0] VALID = 32'h8000_0000;
    localparam logic [31:0] LAST  = 32'h4000_0000;

    typedef struct packed {
        int src; int dst; int len; int nb; int ns;
    } vec_t;

    // src word, dst word, byte length, expected bursts, expected single reads
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{0,   1024, 4,    0,   1},
        '{16,  1100, 16,   1,   0},
        '{40,  1200, 28,   1,   3},
        '{80,  1300, 40,   2,   2},
        '{120, 1400, 0,    0,   0},
        '{130, 1500, 7,    0,   1},
        '{200, 1600, 4000, 128, 0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [RA_W-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic m_req, m_we, m_burst, m_gnt;
    logic [31:0] m_addr, m_wdata;
    logic m_rvalid;
    logic [31:0] m_rdata;
    logic busy, err, bc;
    logic clr_cnt = 1'b0;

    always #2 clk = ~clk;

    chain_dma u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .m_req(m_req), .m_we(m_we), .m_burst(m_burst), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_gnt(m_gnt), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
        .busy(busy), .err(err), .bc(bc)
    );

    function automatic logic [31:0] pat(int i);
        return (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    // Memory slave
    logic [31:0] mem [0:4095];
    int rd_left, cyc;
    logic [11:0] rd_ptr;
    int n_burst, n_single, n_write, n_req_cyc, n_bc;

    assign m_gnt = m_req && (rd_left == 0) && ((cyc % 3) != 1);

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4096; i++) mem[i] <= pat(i);
            rd_left <= 0; cyc <= 0; m_rvalid <= 1'b0; m_rdata <= '0; rd_ptr <= '0;
            n_burst <= 0; n_single <= 0; n_write <= 0; n_req_cyc <= 0; n_bc <= 0;
        end else begin
            cyc <= cyc + 1;
            if (rd_left > 0) begin
                m_rvalid <= 1'b1;
                m_rdata  <= mem[rd_ptr];
                rd_ptr   <= rd_ptr + 1'b1;
                rd_left  <= rd_left - 1;
            end else begin
                m_rvalid <= 1'b0;
            end
            if (m_gnt && !m_we) begin
                rd_left <= m_burst ? 4 : 1;
                rd_ptr  <= m_addr[13:2];
                if (m_burst) n_burst <= n_burst + 1;
                else         n_single <= n_single + 1;
            end
            if (m_gnt && m_we) begin
                mem[m_addr[13:2]] <= m_wdata;
                n_write <= n_write + 1;
            end
            if (clr_cnt) begin
                n_burst <= 0; n_single <= 0; n_write <= 0; n_req_cyc <= 0; n_bc <= 0;
            end else begin
                if (m_req) n_req_cyc <= n_req_cyc + 1;
                if (bc) n_bc <= n_bc + 1;
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = RA_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = RA_W'(a);
        #1 d = reg_rdata;
    endtask

    task automatic set_desc(input int i, input int src_w, input int dst_w, input logic [31:0] ctl);
        wr(4 + 4 * i + 0, 32'(src_w * 4));
        wr(4 + 4 * i + 1, 32'(dst_w * 4));
        wr(4 + 4 * i + 2, ctl);
    endtask

    task automatic clr();
        @(negedge clk); clr_cnt = 1'b1;
        @(negedge clk); clr_cnt = 1'b0;
    endtask

    task automatic wait_bc();
        for (int k = 0; k < 20000 && n_bc == 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic copy_ok(input string req, input int s, input int d, input int words);
        int bad = 0;
        for (int k = 0; k < words; k++) if (mem[d + k] !== pat(s + k)) bad++;
        check_eq(req, 32'(bad), 32'd0);
        check_eq(req, mem[d + words], pat(d + words));
    endtask

    logic [31:0] r;
    bit wd;

    initial begin
        wd = 1'b0;
        fork
            begin
                repeat (4) @(posedge clk);
                @(negedge clk) rst = 1'b0;

                // R1 reset state
                rd(0, r);          check_eq("R1 status", r, 32'd0);
                rd(1, r);          check_eq("R1 pointer", r, 32'd0);
                rd(4 + 4*3 + 2, r); check_eq("R1 ctrl", r, 32'd0);
                check_eq("R1 bc/req", {30'd0, bc, m_req}, 32'd0);

                // Vector table: single descriptor runs
                for (int v = 0; v < NV; v++) begin
                    int words;
                    words = (VECS[v].len >= 2048) ? 512 : VECS[v].len / 4;
                    clr();
                    set_desc(0, VECS[v].src, VECS[v].dst, VALID | LAST | 32'(VECS[v].len));
                    wr(1, 0);
                    wr(0, 1);
                    wait_bc();
                    check_eq("R4 bursts", 32'(n_burst), 32'(VECS[v].nb));
                    check_eq("R4 singles", 32'(n_single), 32'(VECS[v].ns));
                    check_eq("R3 writes", 32'(n_write), 32'(words));
                    copy_ok("R3 R5 copy", VECS[v].src, VECS[v].dst, words);
                    rd(6, r); check_eq("R7 valid cleared", r[31], 1'b0);
                    check_eq("R9 one bc", 32'(n_bc), 32'd1);
                    rd(1, r); check_eq("R11 pointer", r, 32'd1);
                    if (words == 0) check_eq("R6 no request", 32'(n_req_cyc), 32'd0);
                end

                // R2 R10 R11: start and pointer write while busy
                clr();
                set_desc(1, 300, 2300, VALID | LAST | 32'd64);
                wr(1, 1);
                wr(0, 1);
                rd(0, r); check_eq("R2 busy", r, 32'd1);
                wr(0, 1);
                wr(1, 5);
                rd(0, r); check_eq("R10 err set", r, 32'd3);
                wait_bc();
                check_eq("R10 single run", 32'(n_bc), 32'd1);
                rd(1, r); check_eq("R11 ptr write ignored", r, 32'd2);
                rd(0, r); check_eq("R10 err sticky", r, 32'd2);
                copy_ok("R3 copy", 300, 2300, 16);

                // R7 R8: chain wrapping 6 -> 7 -> 0, stopped by invalid slot 1
                clr();
                set_desc(6, 400, 2400, VALID | 32'd8);
                set_desc(7, 420, 2420, VALID | 32'd20);
                set_desc(0, 0, 0, VALID | 32'd0);
                wr(4 + 4*1 + 2, 32'd0);
                wr(1, 6);
                wr(0, 1);
                wait_bc();
                check_eq("R7 chain writes", 32'(n_write), 32'd7);
                check_eq("R4 chain bursts", 32'(n_burst), 32'd1);
                check_eq("R4 chain singles", 32'(n_single), 32'd3);
                copy_ok("R7 copy d6", 400, 2400, 2);
                copy_ok("R7 copy d7", 420, 2420, 5);
                rd(4 + 4*6 + 2, r); check_eq("R7 valid6", r[31], 1'b0);
                rd(4 + 4*7 + 2, r); check_eq("R7 valid7", r[31], 1'b0);
                rd(4 + 4*0 + 2, r); check_eq("R6 valid0", r[31], 1'b0);
                rd(1, r); check_eq("R8 R11 ptr wrap", r, 32'd1);
                check_eq("R9 chain one bc", 32'(n_bc), 32'd1);

                // R8: terminate flag with a valid successor
                clr();
                set_desc(2, 500, 2500, VALID | LAST | 32'd4);
                set_desc(3, 510, 2510, VALID | 32'd4);
                wr(1, 2);
                wr(0, 1);
                wait_bc();
                check_eq("R8 last flag writes", 32'(n_write), 32'd1);
                rd(4 + 4*3 + 2, r); check_eq("R8 successor valid", r[31], 1'b1);
                check_eq("R8 successor untouched", mem[2510], pat(2510));
                rd(1, r); check_eq("R8 ptr", r, 32'd3);

                // R8: run on an invalid slot
                clr();
                wr(4 + 4*5 + 2, 32'd0);
                wr(1, 5);
                wr(0, 1);
                wait_bc();
                check_eq("R8 empty bc", 32'(n_bc), 32'd1);
                check_eq("R8 empty no req", 32'(n_req_cyc), 32'd0);
                rd(1, r); check_eq("R8 empty ptr", r, 32'd5);
                check_eq("R2 idle after run", {31'd0, busy}, 32'd0);
            end
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog act=0 exp=1");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule